// File: doc/BRIEF.md
# Multiplexed Fluorescent Display Scanner

This block keeps the image of a multi-digit vacuum fluorescent display in a small on-chip memory and drives it out one digit at a time. Each digit position owns a 16-bit word. A byte-wide write port fills the memory. The scanner enables one grid after another and presents that digit's segment bits on the segment pins while its grid is on.

The number of scanned grids can be set anywhere from 4 to 11. Five pins are shared between segment and grid roles. As the grid count grows, more of them change from segment drive to grid drive, so the display trades segments per digit against digit count.

A 3-bit dimming level sets how long each grid slot stays lit. A single tick pulse advances the whole scan. A 4-bit active-low LED latch sits beside the scanner and is written through its own strobe.

Top module: `vfd_scan`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, every grid, segment and shared pin is 0 (off), `led_n` is 4'b1111, and the display memory holds zeros.
- R2: When `wr_en` is high at a clock edge and `wr_addr` is at most 21, the byte is stored in digit word `wr_addr>>1`. An even address writes word bits 7:0, where bit i drives segment i+1. An odd address writes bits 15:8, which drive segments 9 to 16. The new value is displayed from the next cycle, including when the digit being written is the one on display.
- R3: A write with `wr_addr` above 21 changes no stored bit, so the display output is unaffected.
- R4: `grid_cnt` values below 4 act as 4, and values above 11 act as 11. The count is taken while reset is low and again at the end of the last slot of each display cycle.
- R5: At most one grid is on at a time. Each slot lasts 16 cycles with `tick` high. Grids step from grid 1 up to the active count and then return to grid 1.
- R6: Let the slot position p run from 0 to 15 and the latched dimming level be k. Output is enabled only for 1 <= p <= 2k+2, so level 7 gives 15 lit ticks. The level is taken while reset is low and at the end of each slot.
- R7: At slot position 0, all grid, segment and shared pins are 0, which blanks every grid change.
- R8: Shared pin j (0 to 4) carries grid 11-j when 11-j is not above the active grid count. Otherwise it carries segment 12+j from the current word.
- R9: `led_wr` loads `led_data[3:0]` into `led_n` at the next edge, where 0 lights an LED. Bits 7:4 are ignored.
- R10: While `tick` is low, the slot position and grid index hold, so the outputs do not change apart from the effect of memory writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Scan step enable |
| wr_en | input | 1 | Display memory byte write strobe |
| wr_addr | input | 8 | Byte address, 0 to 21 valid |
| wr_data | input | 8 | Byte to write |
| grid_cnt | input | 4 | Requested number of grids |
| dim_lvl | input | 3 | Dimming level 0 to 7 |
| led_wr | input | 1 | LED latch write strobe |
| led_data | input | 8 | LED data, bits 3:0 used |
| seg_q | output | 11 | Segments 1 to 11, active high |
| grid_q | output | 6 | Grids 1 to 6, active high |
| dual_q | output | 5 | Shared pins: segment 12+j or grid 11-j |
| led_n | output | 4 | Active-low LED drive |

## Verification
The two functions that can meet in one cycle are a memory write and the scan reading the same digit word. The bench provokes this by aiming writes at the address of the digit currently lit while `tick` is high. It also mixes random writes, including out-of-range addresses, into a running scan whose grid count and dimming level change between display cycles. A reference model built from the requirements predicts every pin in every cycle. A write is judged correct when the lit digit shows the new byte exactly one cycle after the write edge, with no stale or mixed segments.

// File: rtl/vfd_scan.sv
module vfd_scan #(
  parameter int DIGITS     = 11,
  parameter int SEG_W      = 16,
  parameter int MIN_GRIDS  = 4,
  parameter int LED_W      = 4,
  parameter int DIM_W      = 3,
  parameter int POS_W      = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [3:0]  grid_cnt,
  input  logic [2:0]  dim_lvl,
  input  logic        led_wr,
  input  logic [7:0]  led_data,
  output logic [10:0] seg_q,
  output logic [5:0]  grid_q,
  output logic [4:0]  dual_q,
  output logic [3:0]  led_n
);
  localparam int SHARED  = SEG_W - DIGITS;
  localparam int DED_GR  = DIGITS - SHARED;
  localparam int LAST_AD = 2 * DIGITS - 1;
  localparam logic [POS_W-1:0] POS_LAST = '1;

  logic [DIGITS-1:0][SEG_W-1:0] ram;
  logic [POS_W-1:0] pos;
  logic [3:0]       idx;
  logic [3:0]       n_cfg;
  logic [DIM_W-1:0] dim_cfg;
  logic [LED_W-1:0] led_r;

  wire [3:0] n_req = (grid_cnt < 4'(MIN_GRIDS)) ? 4'(MIN_GRIDS) :
                     (grid_cnt > 4'(DIGITS))    ? 4'(DIGITS)    : grid_cnt;
  wire       slot_end  = tick && (pos == POS_LAST);
  wire       cyc_end   = slot_end && (idx == n_cfg - 4'd1);
  wire       addr_ok   = wr_addr <= 8'(LAST_AD);
  wire [4:0] on_limit  = {1'b0, dim_cfg, 1'b0} + 5'd2;
  wire       lit       = (pos != '0) && ({1'b0, pos} <= on_limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram     <= '0;
      pos     <= '0;
      idx     <= '0;
      n_cfg   <= n_req;
      dim_cfg <= dim_lvl;
      led_r   <= '1;
    end else begin
      if (wr_en && addr_ok) begin
        if (wr_addr[0]) ram[wr_addr[4:1]][15:8] <= wr_data;
        else            ram[wr_addr[4:1]][7:0]  <= wr_data;
      end
      if (led_wr) led_r <= led_data[LED_W-1:0];
      if (tick) pos <= pos + 1'b1;
      if (slot_end) begin
        dim_cfg <= dim_lvl;
        if (cyc_end) begin
          idx   <= '0;
          n_cfg <= n_req;
        end else begin
          idx <= idx + 4'd1;
        end
      end
    end
  end

  wire [SEG_W-1:0]  seg_vec  = lit ? ram[idx] : '0;
  wire [DIGITS-1:0] grid_vec = lit ? (DIGITS'(1) << idx) : '0;

  assign seg_q  = seg_vec[DIGITS-1:0];
  assign grid_q = grid_vec[DED_GR-1:0];
  assign led_n  = led_r;

  for (genvar j = 0; j < SHARED; j++) begin : g_shared
    wire as_grid = (4'(DIGITS - j) <= n_cfg);
    assign dual_q[j] = as_grid ? grid_vec[DIGITS-1-j] : seg_vec[DIGITS+j];
  end

  assert_grid_onehot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dual_q & {g_shared[4].as_grid, g_shared[3].as_grid, g_shared[2].as_grid,
                        g_shared[1].as_grid, g_shared[0].as_grid}, grid_q}));
  assert_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pos == '0) |-> (seg_q == '0 && grid_q == '0 && dual_q == '0));
  assert_dim_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (grid_q != '0) |-> ({1'b0, pos} <= {1'b0, dim_cfg, 1'b0} + 5'd2));
  assert_led_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    led_wr |=> (led_n == $past(led_data[3:0])));
  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> ($stable(pos) && $stable(idx)));
  assert_ignore_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_ok) |=> $stable(ram));
  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (n_cfg >= 4'(MIN_GRIDS) && n_cfg <= 4'(DIGITS) && idx < n_cfg));
endmodule

// File: tb/vfd_scan_tb_top.sv
module vfd_scan_tb_top;
  logic clk = 0;
  logic rst_n = 0, tick = 0, wr_en = 0, led_wr = 0;
  logic [7:0] wr_addr = 0, wr_data = 0, led_data = 0;
  logic [3:0] grid_cnt = 4'd2;
  logic [2:0] dim_lvl = 3'd7;
  logic [10:0] seg_q;
  logic [5:0]  grid_q;
  logic [4:0]  dual_q;
  logic [3:0]  led_n;

  always #4 clk = ~clk;

  vfd_scan dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .grid_cnt(grid_cnt), .dim_lvl(dim_lvl), .led_wr(led_wr),
    .led_data(led_data), .seg_q(seg_q), .grid_q(grid_q), .dual_q(dual_q), .led_n(led_n));

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  string seg_tag = "R2";

  logic [15:0] m_ram [11];
  int m_pos = 0, m_idx = 0, m_n = 4, m_dim = 7;
  logic [3:0] m_led = 4'hF;

  function automatic int clampn(int v);
    return v < 4 ? 4 : (v > 11 ? 11 : v);
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (!rst_n) begin
      foreach (m_ram[i]) m_ram[i] = 16'h0;
      m_pos = 0; m_idx = 0; m_n = clampn(grid_cnt); m_dim = dim_lvl; m_led = 4'hF;
    end else begin
      if (wr_en && wr_addr <= 8'd21) begin
        if (wr_addr[0]) m_ram[wr_addr >> 1][15:8] = wr_data;
        else            m_ram[wr_addr >> 1][7:0]  = wr_data;
      end
      if (led_wr) m_led = led_data[3:0];
      if (tick) begin
        if (m_pos == 15) begin
          m_pos = 0;
          m_dim = dim_lvl;
          if (m_idx == m_n - 1) begin m_idx = 0; m_n = clampn(grid_cnt); end
          else m_idx++;
        end else m_pos++;
      end
    end
  endtask

  task automatic compare();
    bit on;
    logic [15:0] sv;
    logic [10:0] gv;
    logic [4:0] dv;
    on = (m_pos != 0) && (m_pos <= 2 * m_dim + 2);
    sv = on ? m_ram[m_idx] : 16'h0;
    gv = on ? (11'd1 << m_idx) : 11'd0;
    for (int j = 0; j < 5; j++) dv[j] = (11 - j <= m_n) ? gv[10 - j] : sv[11 + j];
    check("R5", {10'd0, grid_q}, {10'd0, gv[5:0]});
    check(seg_tag, {5'd0, seg_q}, {5'd0, sv[10:0]});
    check("R8", {11'd0, dual_q}, {11'd0, dv});
    check("R9", {12'd0, led_n}, {12'd0, m_led});
    if (m_pos == 0) check("R7", {seg_q, dual_q}, 16'h0);
    else if (m_pos > 2 * m_dim + 2) check("R6", {seg_q, dual_q}, 16'h0);
    if (!tick) check("R10", {10'd0, grid_q}, {10'd0, gv[5:0]});
  endtask

  task automatic step();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    wr_en = 0; led_wr = 0;
  endtask

  task automatic rand_cycles(int cnt, int tick_pct, int wr_pct, bit bad_addr);
    for (int i = 0; i < cnt; i++) begin
      tick = ($urandom_range(99) < tick_pct);
      if ($urandom_range(99) < wr_pct) begin
        wr_en = 1;
        wr_addr = bad_addr ? 8'(22 + $urandom_range(233)) : 8'($urandom_range(21));
        wr_data = 8'($urandom);
      end
      if ($urandom_range(99) < 3) begin led_wr = 1; led_data = 8'($urandom); end
      step();
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    step(); step();
    check("R1", {seg_q, dual_q}, 16'h0);
    check("R1", {12'd0, led_n}, 16'hF);
    check("R1", {10'd0, grid_q}, 16'h0);
    rst_n = 1;
    tick = 1;
    step();
    check("R1", {seg_q, dual_q}, 16'h0);
    // R4: count 2 clamps to 4; fill memory with directed bytes per address
    for (int a = 0; a < 22; a++) begin
      wr_en = 1; wr_addr = 8'(a); wr_data = 8'(8'h11 * (a % 15) ^ 8'hA5);
      step();
    end
    rand_cycles(800, 100, 0, 0);
    // R4: count above 11 clamps to 11
    grid_cnt = 4'd15; dim_lvl = 3'd0;
    rand_cycles(900, 100, 5, 0);
    seg_tag = "R3";
    rand_cycles(1500, 80, 40, 1);
    seg_tag = "R2";
    // R2: write the digit on display in the same cycle the scan reads it
    for (int i = 0; i < 600; i++) begin
      tick = 1; wr_en = 1;
      wr_addr = 8'(2 * m_idx + (i & 1));
      wr_data = 8'($urandom);
      step();
    end
    for (int g = 4; g <= 11; g++) begin
      grid_cnt = 4'(g); dim_lvl = 3'(g % 8);
      rand_cycles(2200, 90, 10, 0);
    end
    // R10: stall ticks for long stretches
    rand_cycles(3000, 10, 10, 0);
    for (int r = 0; r < 20; r++) begin
      grid_cnt = 4'($urandom); dim_lvl = 3'($urandom);
      rand_cycles(1500, 70, 15, ($urandom_range(3) == 0));
    end
    // R1: reset mid-run clears memory and LED latch
    rst_n = 0; grid_cnt = 4'd7; step();
    rst_n = 1; step();
    check("R1", {12'd0, led_n}, 16'hF);
    rand_cycles(600, 100, 0, 0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule